// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block is the control core of a single-product vending unit with a fixed price of twenty cents. Each clock it may receive one coin event, a nickel, a dime or a quarter, presented as a 2-bit code. It keeps the credit gathered so far as one of four values: 0, 5, 10 or 15 cents. The credit is held in D flip-flops in units of five cents.

The controller is a Mealy machine. When the coin that brings the total to twenty cents or more arrives, `vend` is high in that same cycle. `change_nickels` gives, in that cycle, the surplus over the price as a count of nickels. The credit returns to zero on the next edge, ready for the next sale. In every other cycle both outputs are zero.

The price is a parameter counted in nickels. The default is four nickels. With that price the change runs from 0 to 4 nickels (0 to 20 cents).

Top module: `coin_vend_ctrl`

## Requirements
- R1: After a synchronous reset the credit is zero: a nickel or a dime alone does not vend, and exactly twenty cents of further coins vends with zero change.
- R2: A coin code of 00 (no coin) leaves the credit unchanged and drives `vend` and `change_nickels` to 0.
- R3: Coin code 01 adds 5 cents, 10 adds 10 cents and 11 adds 25 cents. While the running total stays below 20 cents, `vend` stays 0.
- R4: A coin that brings the total to exactly 20 cents raises `vend` in that cycle with `change_nickels` = 0.
- R5: A coin that brings the total above 20 cents raises `vend` with `change_nickels` equal to (total − 20) / 5. For example, 15 + 25 gives 4 and 10 + 25 gives 3.
- R6: A quarter always completes a sale, whatever the credit. At zero credit it gives `change_nickels` = 1.
- R7: After a vend the credit is zero on the next edge. In the next cycle a nickel or a dime alone does not vend.
- R8: `change_nickels` is 0 in every cycle where `vend` is 0.
- R9: While `rst` is high, `vend` and `change_nickels` are 0 whatever the coin code, and the coin is not credited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| coin_code | input | 2 | 00 none, 01 nickel, 10 dime, 11 quarter |
| vend | output | 1 | High in the cycle the completing coin arrives |
| change_nickels | output | CHANGE_W (3) | Change returned, counted in nickels, valid with `vend` |

## Verification
The main function is driven with several coin patterns:
- Runs of nickels only, which reach the price exactly through every credit value.
- Dime pairs, which skip the odd credit values.
- Quarters arriving at each credit value 0, 5, 10 and 15, which sweep the change from 1 to 4.
- Mixed nickel–dime orders that overshoot by one nickel.

The idle cycles placed inside each pattern show whether the credit is held or lost. The coin after each vend shows whether the credit really returned to zero rather than keeping the surplus. A reset issued on top of a pending dime at 15 cents separates a reset that wins from one that lets the coin complete a sale.

// File: rtl/vend_pkg.sv
package vend_pkg;
  // Coin codes presented on coin_code
  typedef enum logic [1:0] {
    COIN_NONE    = 2'b00,
    COIN_NICKEL  = 2'b01,
    COIN_DIME    = 2'b10,
    COIN_QUARTER = 2'b11
  } coin_e;

  // Coin worth in units of five cents
  localparam int NICKEL_UNITS  = 1;
  localparam int DIME_UNITS    = 2;
  localparam int QUARTER_UNITS = 5;
  localparam int UNIT_W        = $clog2(QUARTER_UNITS + 1);
endpackage

// File: rtl/coin_units_dec.sv
module coin_units_dec
  import vend_pkg::*;
(
  input  logic [1:0]        coin,
  output logic [UNIT_W-1:0] units
);
  always_comb begin
    unique case (coin_e'(coin))
      COIN_NICKEL:  units = UNIT_W'(NICKEL_UNITS);
      COIN_DIME:    units = UNIT_W'(DIME_UNITS);
      COIN_QUARTER: units = UNIT_W'(QUARTER_UNITS);
      default:      units = '0;
    endcase
  end
endmodule

// File: rtl/credit_adder.sv
module credit_adder
  import vend_pkg::*;
#(
  parameter int PRICE_UNITS = 4,
  parameter int CREDIT_W    = 2,
  parameter int SUM_W       = 4,
  parameter int CHANGE_W    = 3
) (
  input  logic [CREDIT_W-1:0] credit,
  input  logic [UNIT_W-1:0]   units,
  output logic [CREDIT_W-1:0] next_credit,
  output logic                complete,
  output logic [CHANGE_W-1:0] change
);
  logic [SUM_W-1:0] total;
  logic [SUM_W-1:0] surplus;

  always_comb begin
    total       = SUM_W'(credit) + SUM_W'(units);
    complete    = (total >= SUM_W'(PRICE_UNITS));
    surplus     = total - SUM_W'(PRICE_UNITS);
    next_credit = complete ? '0 : CREDIT_W'(total);
    change      = complete ? CHANGE_W'(surplus) : '0;
  end
endmodule

// File: rtl/credit_reg.sv
module credit_reg #(
  parameter int CREDIT_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CREDIT_W-1:0] d,
  output logic [CREDIT_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
  import vend_pkg::*;
#(
  parameter int PRICE_UNITS = 4,
  parameter int CHANGE_W    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          coin_code,
  output logic                vend,
  output logic [CHANGE_W-1:0] change_nickels
);
  localparam int CREDIT_W = (PRICE_UNITS > 2) ? $clog2(PRICE_UNITS) : 1;
  localparam int MAX_SUM  = PRICE_UNITS - 1 + QUARTER_UNITS;
  localparam int SUM_W    = $clog2(MAX_SUM + 1);

  logic [CREDIT_W-1:0] credit_q;
  logic [CREDIT_W-1:0] credit_d;
  logic [UNIT_W-1:0]   coin_units;
  logic                sale_done;
  logic [CHANGE_W-1:0] sale_change;

  coin_units_dec u_dec (
    .coin  (coin_code),
    .units (coin_units)
  );

  credit_adder #(
    .PRICE_UNITS (PRICE_UNITS),
    .CREDIT_W    (CREDIT_W),
    .SUM_W       (SUM_W),
    .CHANGE_W    (CHANGE_W)
  ) u_add (
    .credit      (credit_q),
    .units       (coin_units),
    .next_credit (credit_d),
    .complete    (sale_done),
    .change      (sale_change)
  );

  credit_reg #(.CREDIT_W(CREDIT_W)) u_state (
    .clk (clk),
    .rst (rst),
    .d   (credit_d),
    .q   (credit_q)
  );

  // Mealy outputs, silenced while reset is held
  assign vend           = sale_done & ~rst;
  assign change_nickels = rst ? '0 : sale_change;
endmodule

// File: rtl/vend_ctrl_checker.sv
module vend_ctrl_checker
  import vend_pkg::*;
#(
  parameter int PRICE_UNITS = 4,
  parameter int CHANGE_W    = 3
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          coin_code,
  input logic                vend,
  input logic [CHANGE_W-1:0] change_nickels
);
  assert_quiet_change_R8: assert property (@(posedge clk) disable iff (rst)
    !vend |-> (change_nickels == '0));

  assert_idle_no_vend_R2: assert property (@(posedge clk) disable iff (rst)
    (coin_code == 2'b00) |-> !vend);

  assert_change_bound_R5: assert property (@(posedge clk) disable iff (rst)
    vend |-> (change_nickels <= CHANGE_W'(QUARTER_UNITS - 1)));

  assert_reset_silent_R9: assert property (@(posedge clk)
    rst |-> (!vend && change_nickels == '0));

  generate
    if (PRICE_UNITS <= QUARTER_UNITS) begin : g_quarter
      assert_quarter_sells_R6: assert property (@(posedge clk) disable iff (rst)
        (coin_code == 2'b11) |-> vend);
    end
    if (PRICE_UNITS > DIME_UNITS) begin : g_zeroed
      assert_credit_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        vend |=> !(vend && coin_code != 2'b11));
      assert_reset_clears_R1: assert property (@(posedge clk)
        ($past(rst) && !rst) |-> !(vend && coin_code != 2'b11));
    end
  endgenerate
endmodule

bind coin_vend_ctrl vend_ctrl_checker #(
  .PRICE_UNITS (PRICE_UNITS),
  .CHANGE_W    (CHANGE_W)
) u_vend_chk (
  .clk            (clk),
  .rst            (rst),
  .coin_code      (coin_code),
  .vend           (vend),
  .change_nickels (change_nickels)
);

// File: tb/test_coin_vend_ctrl.sv
module test_coin_vend_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] coin_code = 2'b00;
  logic       vend;
  logic [2:0] change_nickels;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  coin_vend_ctrl i_coin_vend_ctrl (
    .clk            (clk),
    .rst            (rst),
    .coin_code      (coin_code),
    .vend           (vend),
    .change_nickels (change_nickels)
  );

  // Each row: {coin, expected vend, expected change in nickels}
  localparam int NV = 24;
  localparam logic [5:0] VEC [NV] = '{
    {2'b01,1'b0,3'd0}, {2'b00,1'b0,3'd0}, {2'b01,1'b0,3'd0}, {2'b01,1'b0,3'd0},
    {2'b01,1'b1,3'd0}, {2'b10,1'b0,3'd0}, {2'b10,1'b1,3'd0}, {2'b11,1'b1,3'd1},
    {2'b01,1'b0,3'd0}, {2'b11,1'b1,3'd2}, {2'b10,1'b0,3'd0}, {2'b11,1'b1,3'd3},
    {2'b10,1'b0,3'd0}, {2'b01,1'b0,3'd0}, {2'b11,1'b1,3'd4}, {2'b01,1'b0,3'd0},
    {2'b10,1'b0,3'd0}, {2'b10,1'b1,3'd1}, {2'b00,1'b0,3'd0}, {2'b01,1'b0,3'd0},
    {2'b00,1'b0,3'd0}, {2'b10,1'b0,3'd0}, {2'b00,1'b0,3'd0}, {2'b01,1'b1,3'd0}
  };

  task automatic check(input logic ev, input logic [2:0] ech, input string tag);
    n_cmp++;
    if (vend !== ev || change_nickels !== ech) begin
      n_bad++;
      $display("FAIL %s: vend=%0b change=%0d expected vend=%0b change=%0d",
               tag, vend, change_nickels, ev, ech);
    end
  endtask

  task automatic apply(input logic [1:0] c, input logic ev,
                       input logic [2:0] ech, input string tag);
    @(negedge clk);
    coin_code = c;
    #2;
    check(ev, ech, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check(1'b0, 3'd0, "R9 outputs low in reset");
    @(negedge clk);
    rst = 1'b0;

    // Table walk: R2/R8 on idle rows, R3 on sub-price rows, R4/R5 on sales
    for (int i = 0; i < NV; i++) begin
      string tag;
      if (VEC[i][3] && VEC[i][2:0] == 3'd0)  tag = "R4 exact price";
      else if (VEC[i][3])                     tag = "R5 change";
      else if (VEC[i][5:4] == 2'b00)          tag = "R2 R8 idle hold";
      else                                    tag = "R3 accumulate R8";
      apply(VEC[i][5:4], VEC[i][3], VEC[i][2:0], tag);
    end

    // R6: quarter from zero credit
    apply(2'b11, 1'b1, 3'd1, "R6 quarter at zero");
    // R7: next coin after the sale starts from zero
    apply(2'b10, 1'b0, 3'd0, "R7 dime after vend");
    apply(2'b10, 1'b1, 3'd0, "R7 credit restarted");

    // R9: reset wins over a dime that would complete a sale at 15 cents
    apply(2'b01, 1'b0, 3'd0, "R3 build");
    apply(2'b10, 1'b0, 3'd0, "R3 build to 15");
    @(negedge clk);
    rst = 1'b1;
    coin_code = 2'b10;
    #2;
    check(1'b0, 3'd0, "R9 coin ignored in reset");
    @(negedge clk);
    rst = 1'b0;
    coin_code = 2'b01;
    #2;
    check(1'b0, 3'd0, "R1 nickel after reset");
    apply(2'b10, 1'b0, 3'd0, "R1 credit 15 after reset");
    apply(2'b01, 1'b1, 3'd0, "R1 twenty after reset");
    apply(2'b00, 1'b0, 3'd0, "R8 idle after sale");

    finish_run();
  end
endmodule